// File: doc/BRIEF.md
# Strided single-channel DMA engine

This block is one DMA channel. It copies a run of elements from a source address range to a destination address range over a single-beat memory master port with a valid/ready handshake. Software loads four words through a small write port: source address, destination address, element count and command. The command word sets the element width, the burst length, a separate address stride for each side, a handshake line for each side and the interrupt enable. Setting the enable bit starts the transfer.

The engine works in bursts. It first reads up to four elements into a local buffer, then writes them out in the same order. Before each burst it checks the peripheral request line chosen for each side. It pulses an acknowledge line once the reads of a burst are done and again once the writes are done. When the count runs out, the engine clears the enable bit and can raise a terminal-count status bit. The source and destination registers keep their advanced values, so software can read them back through the register outputs.

Top module: `dma_channel`

## Requirements
- R1: After reset the source, destination, count and command registers read zero, `mem_valid_o` is low and `hs_ack_o` is zero.
- R2: Command bits 21:20 set the element width in bytes: 0 gives 4, 1 gives 2, and 2 or 3 give 1. Elements sit at addresses aligned to their size. A beat drives byte enables over exactly the bytes of the element at its address: all four for a word, 4'b0011 or 4'b1100 picked by address bit 1 for a halfword, and `1 << addr[1:0]` for a byte. Read data is taken from those lanes, and write data is placed on them.
- R3: Command bits 9:8 are the source stride code and bits 13:12 the destination stride code. Code 0 keeps the address fixed. Codes 1, 2 and 3 add 1, 2 and 4 times the element size after each element on that side. The address outputs keep the advanced addresses after the transfer.
- R4: Command bit 3 set gives bursts of four elements; clear gives one element. The last burst is shortened to the remaining count. Each burst reads all of its elements, then writes them in the same order. The 24-bit count falls by the burst length once the burst's writes are done, and it never rises except through a software write.
- R5: When the count reaches zero, command bit 0 (enable) clears. Command bit 1 (terminal-count status) is set at the same time if and only if command bit 2 (interrupt enable) is set.
- R6: Command bits 27:24 choose the source request line and bits 19:16 the destination request line, with 0 meaning none. A burst starts only when every chosen line of `hs_req_i` is high. Until then no memory beat is issued and the count does not change.
- R7: One cycle after the last read beat of a burst is accepted, `hs_ack_o` pulses for one cycle on the source line bit. One cycle after the last write beat is accepted, it pulses on the destination line bit. Line 0 never pulses, and at most one bit is high at a time.
- R8: While `mem_valid_o` is high and `mem_ready_i` is low, the address, direction, byte enables and write data stay stable into the next cycle.
- R9: If software clears the enable bit during a burst, the beat in progress completes and the engine goes idle. The status bit stays clear and the count is not decremented for the partial burst.
- R10: Setting enable while the count is zero issues no memory beat. The enable bit then clears, and the status bit is set if interrupt enable is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_sel_i | input | 2 | Register select: 0 source, 1 destination, 2 count, 3 command |
| cfg_wdata_i | input | 32 | Register write data |
| src_addr_o | output | 32 | Current source address |
| dst_addr_o | output | 32 | Current destination address |
| count_o | output | 24 | Remaining element count |
| cmd_o | output | 32 | Command register, including enable and status |
| mem_valid_o | output | 1 | Memory beat request |
| mem_we_o | output | 1 | Beat is a write |
| mem_addr_o | output | 32 | Beat address |
| mem_be_o | output | 4 | Byte enables |
| mem_wdata_o | output | 32 | Write data |
| mem_ready_i | input | 1 | Beat accepted this cycle |
| mem_rdata_i | input | 32 | Read data, valid with mem_ready_i on a read |
| hs_req_i | input | 16 | Peripheral request lines |
| hs_ack_o | output | 16 | Peripheral acknowledge pulses |

## Verification
The in-RTL assertions check the following on every cycle:
- the memory request is held stable while stalled;
- the number of byte enables matches the element width;
- the acknowledge vector never has more than one bit high, and line 0 never pulses;
- a burst never starts without its chosen request lines;
- the count never rises except through a software write;
- the status bit rises only at the end of a transfer with interrupt enable set;
- a beat accepted after the enable was dropped returns the engine to idle.

Only the bench scenarios can show the following:
- that the stride codes, width lanes and burst ordering move the right data to the right bytes;
- that shortened last bursts and fixed-address sides produce the right final register values;
- that an abort leaves the count and status untouched;
- that a zero count completes without traffic.

// File: rtl/dma_pkg.sv
package dma_pkg;

  localparam int unsigned WORD_W    = 32;
  localparam int unsigned CMD_EN    = 0;
  localparam int unsigned CMD_TC    = 1;
  localparam int unsigned CMD_IE    = 2;
  localparam int unsigned CMD_BURST = 3;
  localparam int unsigned CMD_SSTR  = 8;
  localparam int unsigned CMD_DSTR  = 12;
  localparam int unsigned CMD_DLINE = 16;
  localparam int unsigned CMD_WIDTH = 20;
  localparam int unsigned CMD_SLINE = 24;

  typedef enum logic [1:0] {
    SEL_SRC = 2'd0,
    SEL_DST = 2'd1,
    SEL_CNT = 2'd2,
    SEL_CMD = 2'd3
  } cfg_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } xfer_state_e;

  typedef struct packed {
    logic       en;
    logic       ie;
    logic       burst4;
    logic [2:0] esize;
    logic [4:0] src_step;
    logic [4:0] dst_step;
    logic [3:0] src_line;
    logic [3:0] dst_line;
  } cmd_dec_t;

  // effective lane offset: words use lane 0, halfwords an even lane
  function automatic logic [1:0] lane_lo(input logic [1:0] lo, input logic [2:0] esz);
    case (esz)
      3'd4:    return 2'b00;
      3'd2:    return {lo[1], 1'b0};
      default: return lo;
    endcase
  endfunction

  function automatic logic [3:0] lane_be(input logic [1:0] lo, input logic [2:0] esz);
    case (esz)
      3'd4:    return 4'hF;
      3'd2:    return 4'h3 << lane_lo(lo, esz);
      default: return 4'h1 << lane_lo(lo, esz);
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] lane_mask(input logic [2:0] esz);
    case (esz)
      3'd4:    return 32'hFFFF_FFFF;
      3'd2:    return 32'h0000_FFFF;
      default: return 32'h0000_00FF;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] lane_take(input logic [WORD_W-1:0] word,
                                                  input logic [1:0] lo, input logic [2:0] esz);
    return (word >> {lane_lo(lo, esz), 3'b000}) & lane_mask(esz);
  endfunction

  function automatic logic [WORD_W-1:0] lane_put(input logic [WORD_W-1:0] elem,
                                                 input logic [1:0] lo, input logic [2:0] esz);
    return (elem & lane_mask(esz)) << {lane_lo(lo, esz), 3'b000};
  endfunction

endpackage

// File: rtl/dma_cmd_decode.sv
module dma_cmd_decode
  import dma_pkg::*;
(
  input  logic [WORD_W-1:0] cmd_i,
  output cmd_dec_t          dec_o
);

  logic [2:0] esize;
  logic       unused_cmd_bits;

  always_comb begin
    case (cmd_i[CMD_WIDTH +: 2])
      2'd0:    esize = 3'd4;
      2'd1:    esize = 3'd2;
      default: esize = 3'd1;
    endcase
  end

  function automatic logic [4:0] step_of(input logic [1:0] code, input logic [2:0] esz);
    case (code)
      2'd0:    return 5'd0;
      2'd1:    return {2'b00, esz};
      2'd2:    return {1'b0, esz, 1'b0};
      default: return {esz, 2'b00};
    endcase
  endfunction

  always_comb begin
    dec_o.en       = cmd_i[CMD_EN];
    dec_o.ie       = cmd_i[CMD_IE];
    dec_o.burst4   = cmd_i[CMD_BURST];
    dec_o.esize    = esize;
    dec_o.src_step = step_of(cmd_i[CMD_SSTR +: 2], esize);
    dec_o.dst_step = step_of(cmd_i[CMD_DSTR +: 2], esize);
    dec_o.src_line = cmd_i[CMD_SLINE +: 4];
    dec_o.dst_line = cmd_i[CMD_DLINE +: 4];
  end

  assign unused_cmd_bits = ^{cmd_i[CMD_TC], cmd_i[7:4], cmd_i[11:10], cmd_i[15:14], cmd_i[31:28]};

endmodule

// File: rtl/dma_burst_ctl.sv
module dma_burst_ctl
  import dma_pkg::*;
#(
  parameter  int unsigned CNT_W     = 24,
  parameter  int unsigned BUF_DEPTH = 4,
  parameter  int unsigned HS_LINES  = 16,
  localparam int unsigned IDX_W     = (BUF_DEPTH > 1) ? $clog2(BUF_DEPTH) : 1,
  localparam int unsigned LEN_W     = $clog2(BUF_DEPTH + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  cmd_dec_t            dec_i,
  input  logic [CNT_W-1:0]    cnt_i,
  input  logic [HS_LINES-1:0] hs_req_i,
  input  logic                mem_ready_i,
  output xfer_state_e         state_o,
  output logic [IDX_W-1:0]    idx_o,
  output logic [LEN_W-1:0]    blen_o,
  output logic                rd_fire_o,
  output logic                wr_fire_o,
  output logic                burst_end_o,
  output logic                empty_end_o,
  output logic [HS_LINES-1:0] hs_ack_o
);

  xfer_state_e         st_q;
  logic [IDX_W-1:0]    idx_q;
  logic [LEN_W-1:0]    blen_q, blen_nxt;
  logic [HS_LINES-1:0] ack_q;
  logic                gate_ok, last_beat;

  assign gate_ok = (dec_i.src_line == '0 || hs_req_i[dec_i.src_line]) &&
                   (dec_i.dst_line == '0 || hs_req_i[dec_i.dst_line]);

  always_comb begin
    if (!dec_i.burst4)                   blen_nxt = LEN_W'(1);
    else if (cnt_i < CNT_W'(BUF_DEPTH)) blen_nxt = LEN_W'(cnt_i);
    else                                 blen_nxt = LEN_W'(BUF_DEPTH);
  end

  assign last_beat = (LEN_W'(idx_q) + LEN_W'(1)) == blen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      blen_q <= '0;
      ack_q  <= '0;
    end else begin
      ack_q <= '0;
      case (st_q)
        ST_IDLE: begin
          if (dec_i.en && cnt_i != '0 && gate_ok) begin
            st_q   <= ST_READ;
            idx_q  <= '0;
            blen_q <= blen_nxt;
          end
        end
        ST_READ: begin
          if (mem_ready_i) begin
            if (!dec_i.en) begin
              st_q <= ST_IDLE;
            end else if (last_beat) begin
              st_q  <= ST_WRITE;
              idx_q <= '0;
              if (dec_i.src_line != '0) ack_q[dec_i.src_line] <= 1'b1;
            end else begin
              idx_q <= idx_q + IDX_W'(1);
            end
          end
        end
        ST_WRITE: begin
          if (mem_ready_i) begin
            if (!dec_i.en) begin
              st_q <= ST_IDLE;
            end else if (last_beat) begin
              st_q <= ST_IDLE;
              if (dec_i.dst_line != '0) ack_q[dec_i.dst_line] <= 1'b1;
            end else begin
              idx_q <= idx_q + IDX_W'(1);
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o     = st_q;
  assign idx_o       = idx_q;
  assign blen_o      = blen_q;
  assign rd_fire_o   = (st_q == ST_READ) && mem_ready_i;
  assign wr_fire_o   = (st_q == ST_WRITE) && mem_ready_i;
  assign burst_end_o = wr_fire_o && dec_i.en && last_beat;
  assign empty_end_o = (st_q == ST_IDLE) && dec_i.en && (cnt_i == '0);
  assign hs_ack_o    = ack_q;

  // R7
  ack_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hs_ack_o) && !hs_ack_o[0]);

  // R6
  start_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_READ && $past(st_q) == ST_IDLE) |-> $past(gate_ok));

  // R9
  abort_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_IDLE && mem_ready_i && !dec_i.en) |=> st_q == ST_IDLE);

endmodule

// File: rtl/dma_channel.sv
module dma_channel
  import dma_pkg::*;
#(
  parameter  int unsigned ADDR_W    = 32,
  parameter  int unsigned CNT_W     = 24,
  parameter  int unsigned BUF_DEPTH = 4,
  parameter  int unsigned HS_LINES  = 16,
  localparam int unsigned IDX_W     = (BUF_DEPTH > 1) ? $clog2(BUF_DEPTH) : 1,
  localparam int unsigned LEN_W     = $clog2(BUF_DEPTH + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cfg_we_i,
  input  logic [1:0]          cfg_sel_i,
  input  logic [WORD_W-1:0]   cfg_wdata_i,
  output logic [ADDR_W-1:0]   src_addr_o,
  output logic [ADDR_W-1:0]   dst_addr_o,
  output logic [CNT_W-1:0]    count_o,
  output logic [WORD_W-1:0]   cmd_o,
  output logic                mem_valid_o,
  output logic                mem_we_o,
  output logic [ADDR_W-1:0]   mem_addr_o,
  output logic [3:0]          mem_be_o,
  output logic [WORD_W-1:0]   mem_wdata_o,
  input  logic                mem_ready_i,
  input  logic [WORD_W-1:0]   mem_rdata_i,
  input  logic [HS_LINES-1:0] hs_req_i,
  output logic [HS_LINES-1:0] hs_ack_o
);

  logic [ADDR_W-1:0] src_q, dst_q;
  logic [CNT_W-1:0]  cnt_q, cnt_left;
  logic [WORD_W-1:0] cmd_q;
  logic [WORD_W-1:0] ebuf_q [BUF_DEPTH];
  cmd_dec_t          dec;
  xfer_state_e       state;
  logic [IDX_W-1:0]  idx;
  logic [LEN_W-1:0]  blen;
  logic              rd_fire, wr_fire, burst_end, empty_end;
  logic              wr_src, wr_dst, wr_cnt, wr_cmd, xfer_done;
  cfg_sel_e          sel;

  assign sel    = cfg_sel_e'(cfg_sel_i);
  assign wr_src = cfg_we_i && sel == SEL_SRC;
  assign wr_dst = cfg_we_i && sel == SEL_DST;
  assign wr_cnt = cfg_we_i && sel == SEL_CNT;
  assign wr_cmd = cfg_we_i && sel == SEL_CMD;

  dma_cmd_decode i_decode (
    .cmd_i (cmd_q),
    .dec_o (dec)
  );

  dma_burst_ctl #(
    .CNT_W     (CNT_W),
    .BUF_DEPTH (BUF_DEPTH),
    .HS_LINES  (HS_LINES)
  ) i_ctl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .dec_i       (dec),
    .cnt_i       (cnt_q),
    .hs_req_i    (hs_req_i),
    .mem_ready_i (mem_ready_i),
    .state_o     (state),
    .idx_o       (idx),
    .blen_o      (blen),
    .rd_fire_o   (rd_fire),
    .wr_fire_o   (wr_fire),
    .burst_end_o (burst_end),
    .empty_end_o (empty_end),
    .hs_ack_o    (hs_ack_o)
  );

  assign cnt_left  = cnt_q - CNT_W'(blen);
  assign xfer_done = (burst_end && cnt_left == '0) || empty_end;

  // software writes take priority over engine updates
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q <= '0;
      dst_q <= '0;
      cnt_q <= '0;
      cmd_q <= '0;
    end else begin
      if (wr_src)       src_q <= cfg_wdata_i[ADDR_W-1:0];
      else if (rd_fire) src_q <= src_q + ADDR_W'(dec.src_step);

      if (wr_dst)       dst_q <= cfg_wdata_i[ADDR_W-1:0];
      else if (wr_fire) dst_q <= dst_q + ADDR_W'(dec.dst_step);

      if (wr_cnt)         cnt_q <= cfg_wdata_i[CNT_W-1:0];
      else if (burst_end) cnt_q <= cnt_left;

      if (wr_cmd) begin
        cmd_q <= cfg_wdata_i;
      end else if (xfer_done) begin
        cmd_q[CMD_EN] <= 1'b0;
        if (cmd_q[CMD_IE]) cmd_q[CMD_TC] <= 1'b1;
      end
    end
  end

  generate
    for (genvar g = 0; g < BUF_DEPTH; g++) begin : g_ebuf
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                             ebuf_q[g] <= '0;
        else if (rd_fire && idx == IDX_W'(g)) ebuf_q[g] <= lane_take(mem_rdata_i, src_q[1:0], dec.esize);
      end
    end
  endgenerate

  assign mem_valid_o = state != ST_IDLE;
  assign mem_we_o    = state == ST_WRITE;
  assign mem_addr_o  = mem_we_o ? dst_q : src_q;
  assign mem_be_o    = mem_we_o ? lane_be(dst_q[1:0], dec.esize) : lane_be(src_q[1:0], dec.esize);
  assign mem_wdata_o = mem_we_o ? lane_put(ebuf_q[idx], dst_q[1:0], dec.esize) : '0;

  assign src_addr_o = src_q;
  assign dst_addr_o = dst_q;
  assign count_o    = cnt_q;
  assign cmd_o      = cmd_q;

  // R8
  mem_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_valid_o && !mem_ready_i) |=> mem_valid_o && $stable(mem_addr_o) && $stable(mem_we_o)
                                      && $stable(mem_be_o) && $stable(mem_wdata_o));

  // R2
  lane_be_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o |-> $countones(mem_be_o) == int'(dec.esize));

  // R4
  cnt_down_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(wr_cnt) |-> cnt_q <= $past(cnt_q));

  // R5
  tc_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(cmd_q[CMD_TC]) && !$past(wr_cmd)) |-> !cmd_q[CMD_EN] && cnt_q == '0 && $past(cmd_q[CMD_IE]));

endmodule

// File: tb/test_dma_channel.sv
module test_dma_channel;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] src_o, dst_o, cmd_o;
  logic [23:0] count_o;
  logic        mem_valid, mem_we, mem_ready = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0]  mem_be;
  logic [15:0] hs_req = '0, hs_ack;

  always #10 clk = ~clk;

  dma_channel i_dma_channel (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel), .cfg_wdata_i(cfg_wdata),
    .src_addr_o(src_o), .dst_addr_o(dst_o), .count_o(count_o), .cmd_o(cmd_o),
    .mem_valid_o(mem_valid), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_be_o(mem_be),
    .mem_wdata_o(mem_wdata), .mem_ready_i(mem_ready), .mem_rdata_i(mem_rdata),
    .hs_req_i(hs_req), .hs_ack_o(hs_ack)
  );

  logic [7:0] mem [256];
  logic [7:0] ra;
  assign ra = mem_addr[7:0];
  assign mem_rdata = {mem[{ra[7:2], 2'd3}], mem[{ra[7:2], 2'd2}], mem[{ra[7:2], 2'd1}], mem[{ra[7:2], 2'd0}]};

  typedef struct {
    bit          is_ack;
    logic [31:0] addr;
    logic [3:0]  be;
    logic [31:0] data;
    int          line;
  } exp_t;

  exp_t sb[$];
  int   n_chk = 0, n_fail = 0, valid_cycles = 0, ready_mode = 0, cyc = 0;
  bit   ended = 1'b0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!ended) begin
      ended = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  function automatic logic [31:0] be_mask(input logic [3:0] be);
    return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
  endfunction

  // monitor: acks, ready generation, write-beat scoreboard
  exp_t e;
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (hs_ack != '0) begin
        if (sb.size() == 0 || !sb[0].is_ack) begin
          chk("R7", "unexpected ack", {16'h0, hs_ack}, 32'h0);
        end else begin
          e = sb.pop_front();
          chk("R7", "ack line", {16'h0, hs_ack}, 32'h1 << e.line);
        end
      end
      case (ready_mode)
        0:       mem_ready = 1'b1;
        1:       mem_ready = (cyc % 3) != 0;
        default: mem_ready = 1'b0;
      endcase
      if (mem_valid) valid_cycles++;
      if (mem_valid && mem_ready && mem_we) begin
        if (sb.size() == 0 || sb[0].is_ack) begin
          chk("R4", "write beat not expected", mem_addr, ~mem_addr);
        end else begin
          e = sb.pop_front();
          chk("R3", "write addr", mem_addr, e.addr);
          chk("R2", "write be", {28'h0, mem_be}, {28'h0, e.be});
          chk("R2", "write data", mem_wdata & be_mask(mem_be), e.data);
        end
      end
    end
  end

  task automatic cfg(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic logic [31:0] mk_cmd(input bit en, input bit ie, input bit b4, input logic [1:0] wcode,
                                         input logic [1:0] sstr, input logic [1:0] dstr,
                                         input logic [3:0] sline, input logic [3:0] dline);
    return 32'(en) | (32'(ie) << 2) | (32'(b4) << 3) | (32'(sstr) << 8) | (32'(dstr) << 12)
         | (32'(dline) << 16) | (32'(wcode) << 20) | (32'(sline) << 24);
  endfunction

  function automatic int esz_of(input logic [31:0] cmd);
    return (cmd[21:20] == 2'd0) ? 4 : (cmd[21:20] == 2'd1) ? 2 : 1;
  endfunction

  function automatic int step_of(input logic [1:0] code, input int esz);
    return (code == 2'd0) ? 0 : esz << (code - 1);
  endfunction

  // driver: push expected items, then program the channel
  task automatic start_xfer(input logic [31:0] src, input logic [31:0] dst, input int cnt,
                            input logic [31:0] cmd, output logic [31:0] s_end, output logic [31:0] d_end);
    int          esz = esz_of(cmd);
    int          b   = cmd[3] ? 4 : 1;
    int          ss  = step_of(cmd[9:8], esz);
    int          ds  = step_of(cmd[13:12], esz);
    int          rem = cnt;
    logic [31:0] s   = src;
    logic [31:0] d   = dst;
    logic [31:0] el [4];
    while (rem > 0) begin
      int bl = (rem < b) ? rem : b;
      for (int k = 0; k < bl; k++) begin
        el[k] = '0;
        for (int j = 0; j < esz; j++) el[k] |= 32'(mem[8'(s + 32'(j))]) << (8 * j);
        s += 32'(ss);
      end
      if (cmd[27:24] != 4'd0) sb.push_back('{1'b1, '0, '0, '0, int'(cmd[27:24])});
      for (int k = 0; k < bl; k++) begin
        logic [3:0] be = 4'(((1 << esz) - 1) << d[1:0]);
        sb.push_back('{1'b0, d, be, el[k] << (8 * d[1:0]), 0});
        d += 32'(ds);
      end
      if (cmd[19:16] != 4'd0) sb.push_back('{1'b1, '0, '0, '0, int'(cmd[19:16])});
      rem -= bl;
    end
    s_end = s;
    d_end = d;
    cfg(2'd0, src);
    cfg(2'd1, dst);
    cfg(2'd2, 32'(cnt));
    cfg(2'd3, cmd);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (!cmd_o[0] && !mem_valid) break;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic end_checks(input string req, input logic [31:0] s_end, input logic [31:0] d_end,
                            input logic [31:0] cmd);
    chk("R3", {req, " src end"}, src_o, s_end);
    chk("R3", {req, " dst end"}, dst_o, d_end);
    chk("R4", {req, " count end"}, {8'h0, count_o}, 32'h0);
    chk("R5", {req, " cmd end"}, cmd_o, (cmd & ~32'h1) | (cmd[2] ? 32'h2 : 32'h0));
    chk("R4", {req, " all beats seen"}, sb.size(), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R4 watchdog: actual=timeout expected=completion");
    finish_up();
  end

  initial begin
    logic [31:0] cmd, se, de;
    int          vc;
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 13 + 7);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "src", src_o, 0);
    chk("R1", "dst", dst_o, 0);
    chk("R1", "count", {8'h0, count_o}, 0);
    chk("R1", "cmd", cmd_o, 0);
    chk("R1", "valid/ack", {15'h0, mem_valid, hs_ack}, 0);

    // R4 R5: words, bursts of four, unit strides, interrupt enabled
    ready_mode = 0;
    cmd = mk_cmd(1, 1, 1, 2'd0, 2'd1, 2'd1, 4'd0, 4'd0);
    start_xfer(32'h00, 32'h80, 8, cmd, se, de);
    wait_idle();
    end_checks("R4 word burst", se, de, cmd);

    // R2 R8: byte width code 3, single bursts, source stride code 2, stalling memory, no interrupt
    ready_mode = 1;
    cmd = mk_cmd(1, 0, 0, 2'd3, 2'd2, 2'd1, 4'd0, 4'd0);
    start_xfer(32'h41, 32'hC3, 5, cmd, se, de);
    wait_idle();
    end_checks("R2 byte", se, de, cmd);

    // R7 R3: halfwords, shortened last burst, source stride code 3, fixed destination, handshakes 3 and 5
    hs_req = 16'h0028;
    cmd = mk_cmd(1, 1, 1, 2'd1, 2'd3, 2'd0, 4'd3, 4'd5);
    start_xfer(32'h02, 32'hE6, 6, cmd, se, de);
    wait_idle();
    end_checks("R7 half", se, de, cmd);
    hs_req = '0;

    // R6: source line 7 held low blocks the transfer
    ready_mode = 0;
    cmd = mk_cmd(1, 0, 0, 2'd0, 2'd1, 2'd1, 4'd7, 4'd0);
    start_xfer(32'h10, 32'hA0, 2, cmd, se, de);
    vc = valid_cycles;
    repeat (20) @(negedge clk);
    chk("R6", "no beats while gated", valid_cycles - vc, 0);
    chk("R6", "count while gated", {8'h0, count_o}, 2);
    chk("R6", "src while gated", src_o, 32'h10);
    hs_req[7] = 1'b1;
    wait_idle();
    end_checks("R6 released", se, de, cmd);
    hs_req = '0;

    // R9: drop enable while the first read is stalled
    ready_mode = 2;
    cmd = mk_cmd(1, 1, 1, 2'd0, 2'd1, 2'd1, 4'd0, 4'd0);
    cfg(2'd0, 32'h20);
    cfg(2'd1, 32'h90);
    cfg(2'd2, 32'd8);
    cfg(2'd3, cmd);
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (mem_valid) break;
    end
    cfg(2'd3, cmd & ~32'h1);
    @(negedge clk);
    ready_mode = 0;
    repeat (10) @(negedge clk);
    chk("R9", "src after abort", src_o, 32'h24);
    chk("R9", "dst after abort", dst_o, 32'h90);
    chk("R9", "count after abort", {8'h0, count_o}, 8);
    chk("R9", "cmd after abort", cmd_o, cmd & ~32'h1);
    chk("R9", "idle after abort", {31'h0, mem_valid}, 0);

    // R10: enable with zero count
    cfg(2'd2, 32'd0);
    vc = valid_cycles;
    cmd = mk_cmd(1, 1, 0, 2'd0, 2'd1, 2'd1, 4'd0, 4'd0);
    cfg(2'd3, cmd);
    repeat (4) @(negedge clk);
    chk("R10", "cmd after empty start", cmd_o, (cmd & ~32'h1) | 32'h2);
    chk("R10", "no beats", valid_cycles - vc, 0);
    chk("R10", "no acks pending", sb.size(), 0);

    finish_up();
  end

endmodule